// File: doc/BRIEF.md
# Self-reconfiguration trigger controller

This block starts an FPGA's reload of itself from one of four flash images. User logic raises a request with a 2-bit image number, where image 0 is the golden fallback. The controller then works through a fixed order of steps. It first forces the dual-purpose configuration pins that serve as user outputs to their required idle levels. It waits long enough for those pins to settle (800 ns plus a small margin). It then presents the image number and raises the capture enable. Only after that does it fire a clean, register-driven configuration request pulse of fixed width.

The reconfiguration engine returns a pass/fail flag. The controller passes this flag through a two-flop synchronizer and keeps it in a sticky status bit that the user can clear. While that bit is set, only the golden image may be requested, so a failed application image is not retried in a loop. An abort input cancels a sequence that has not yet reached the request pulse. The clock period is a parameter. Elaboration stops if the period is shorter than 10 ns (above 100 MHz) or if the pulse width is below 4 cycles.

Top module: `reconf_trigger_ctrl`

## Requirements
- R1: After reset, busy, cfg_ena, cfg_config, err_live and err_flag are 0, cfg_sel is 0, and pin_out equals pin_user.
- R2: A request (req_valid high at a clock edge) is accepted only if the controller is idle, abort is low, and either err_flag is 0 or req_image is 0. After the accepting edge, busy is 1 and cfg_sel equals req_image.
- R3: From the cycle after acceptance until busy falls, pin_out equals the PIN_IDLE_LEVEL parameter (default 3'b101). In all other cycles it equals pin_user.
- R4: cfg_ena rises exactly SETTLE_CYC = ceil(800000 / CLK_PERIOD_PS) + 2 cycles after acceptance (42 cycles at the default 20 ns period). It stays high until busy falls.
- R5: cfg_config rises ARM_CYCLES (default 2) cycles after cfg_ena. It stays high for exactly PULSE_CYCLES (default 4) cycles. Then cfg_config, cfg_ena and busy all fall at the same edge.
- R6: req_valid while busy has no effect: cfg_sel and the timing of the running sequence are unchanged.
- R7: Abort during settling or while the enable is held before the pulse returns the controller to idle at the next edge, with no pulse. Abort during the pulse has no effect. Abort together with a request in idle blocks the request.
- R8: err_live follows cfg_error_in after two clock edges. err_flag is set at the third edge after cfg_error_in rises.
- R9: err_flag stays 1 until err_clear is high at an edge while err_live is 0. If a set and a clear meet at the same edge, the set wins.
- R10: While err_flag is 1, requests for images 1 to 3 are refused (busy stays 0, cfg_sel unchanged), and a request for image 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reconfiguration clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Reconfiguration request |
| req_image | input | 2 | Image number for the request (0 = golden) |
| abort | input | 1 | Cancel a sequence before its pulse; blocks a request in idle |
| err_clear | input | 1 | Clear the sticky error bit |
| pin_user | input | PIN_W | User-mode values for the dual-purpose pins |
| pin_out | output | PIN_W | Values driven onto the dual-purpose pins |
| busy | output | 1 | A sequence is in progress |
| cfg_sel | output | 2 | Image select to the reconfiguration port |
| cfg_ena | output | 1 | Select-capture enable to the reconfiguration port |
| cfg_config | output | 1 | Configuration request pulse |
| cfg_error_in | input | 1 | Pass/fail status from the reconfiguration engine (1 = failed) |
| err_live | output | 1 | Synchronized error status |
| err_flag | output | 1 | Sticky error status |

## Verification
Two events can land on the same edge: the synchronized error reaching the sticky bit, and a user clear of that bit. The bench holds err_clear high from the moment cfg_error_in rises. The bit must still read 1 after the third edge, and it must clear only after the live error has gone low. A second collision is a request arriving together with abort in idle, or during a busy sequence. Here the bench judges by busy, cfg_sel and the pulse timing, compared against a cycle-count model.

// File: rtl/reconf_pkg.sv
package reconf_pkg;

    localparam int unsigned IMG_W             = 2;
    localparam int unsigned MIN_CLK_PERIOD_PS = 10000;
    localparam int unsigned SETTLE_MIN_PS     = 800000;
    localparam int unsigned SETTLE_MARGIN     = 2;
    localparam int unsigned MIN_PULSE_CYCLES  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ARM,
        ST_PULSE
    } seq_state_e;

    typedef struct packed {
        logic             valid;
        logic [IMG_W-1:0] image;
    } reconf_req_t;

    typedef struct packed {
        logic ena;
        logic cfg;
    } port_drive_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/reconf_err_sync.sv
module reconf_err_sync
    import reconf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_in,
    input  logic err_clear,
    output logic err_live,
    output logic err_flag
);

    logic meta_q;
    logic sync_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            meta_q <= err_in;
            sync_q <= meta_q;
            // a set from the synchronizer outranks a clear in the same cycle
            flag_q <= sync_q | (flag_q & ~err_clear);
        end
    end

    assign err_live = sync_q;
    assign err_flag = flag_q;

endmodule

// File: rtl/reconf_seq.sv
module reconf_seq
    import reconf_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned ARM_CYCLES    = 2,
    parameter int unsigned PULSE_CYCLES  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  reconf_req_t      req,
    input  logic             abort,
    input  logic             err_block,
    output logic             busy,
    output logic [IMG_W-1:0] sel,
    output port_drive_t      drive
);

    localparam int unsigned SETTLE_CYC = ceil_div(SETTLE_MIN_PS, CLK_PERIOD_PS) + SETTLE_MARGIN;
    localparam int unsigned MAX_CNT    = max3(SETTLE_CYC, ARM_CYCLES, PULSE_CYCLES);
    localparam int unsigned CNT_W      = $clog2(MAX_CNT + 1);

    if (CLK_PERIOD_PS < MIN_CLK_PERIOD_PS) begin : g_clk_too_fast
        $error("reconf_seq: clock period below 10 ns exceeds the 100 MHz limit");
    end
    if (PULSE_CYCLES < MIN_PULSE_CYCLES) begin : g_pulse_too_short
        $error("reconf_seq: request pulse must last at least 4 cycles");
    end
    if (ARM_CYCLES < 1) begin : g_arm_too_short
        $error("reconf_seq: enable must lead the request by at least one cycle");
    end

    seq_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IMG_W-1:0] sel_q;
    port_drive_t      drive_q, drive_n;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && req.valid && !abort &&
                    (!err_block || (req.image == '0));

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_n = ST_SETTLE;
                    cnt_n   = CNT_W'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (abort) begin
                    state_n = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_n = ST_ARM;
                    cnt_n   = CNT_W'(ARM_CYCLES - 1);
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            ST_ARM: begin
                if (abort) begin
                    state_n = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_n = ST_PULSE;
                    cnt_n   = CNT_W'(PULSE_CYCLES - 1);
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            ST_PULSE: begin
                if (cnt_q == '0) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
        drive_n.ena = (state_n == ST_ARM) || (state_n == ST_PULSE);
        drive_n.cfg = (state_n == ST_PULSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
            drive_q <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            drive_q <= drive_n;
            if (accept) begin
                sel_q <= req.image;
            end
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign sel   = sel_q;
    assign drive = drive_q;

endmodule

// File: rtl/reconf_pin_cond.sv
module reconf_pin_cond #(
    parameter int unsigned          PIN_W          = 3,
    parameter logic [PIN_W-1:0]     PIN_IDLE_LEVEL = 3'b101
) (
    input  logic             force_idle,
    input  logic [PIN_W-1:0] pin_user,
    output logic [PIN_W-1:0] pin_out
);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign pin_out[i] = force_idle ? PIN_IDLE_LEVEL[i] : pin_user[i];
    end

endmodule

// File: rtl/reconf_trigger_ctrl.sv
module reconf_trigger_ctrl
    import reconf_pkg::*;
#(
    parameter int unsigned      CLK_PERIOD_PS  = 20000,
    parameter int unsigned      ARM_CYCLES     = 2,
    parameter int unsigned      PULSE_CYCLES   = 4,
    parameter int unsigned      PIN_W          = 3,
    parameter logic [PIN_W-1:0] PIN_IDLE_LEVEL = 3'b101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_image,
    input  logic             abort,
    input  logic             err_clear,
    input  logic [PIN_W-1:0] pin_user,
    output logic [PIN_W-1:0] pin_out,
    output logic             busy,
    output logic [1:0]       cfg_sel,
    output logic             cfg_ena,
    output logic             cfg_config,
    input  logic             cfg_error_in,
    output logic             err_live,
    output logic             err_flag
);

    reconf_req_t  req;
    port_drive_t  drive;
    logic         busy_w;

    assign req.valid = req_valid;
    assign req.image = req_image;

    reconf_err_sync u_err (
        .clk       (clk),
        .rst       (rst),
        .err_in    (cfg_error_in),
        .err_clear (err_clear),
        .err_live  (err_live),
        .err_flag  (err_flag)
    );

    reconf_seq #(
        .CLK_PERIOD_PS (CLK_PERIOD_PS),
        .ARM_CYCLES    (ARM_CYCLES),
        .PULSE_CYCLES  (PULSE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .abort     (abort),
        .err_block (err_flag),
        .busy      (busy_w),
        .sel       (cfg_sel),
        .drive     (drive)
    );

    reconf_pin_cond #(
        .PIN_W          (PIN_W),
        .PIN_IDLE_LEVEL (PIN_IDLE_LEVEL)
    ) u_pins (
        .force_idle (busy_w),
        .pin_user   (pin_user),
        .pin_out    (pin_out)
    );

    assign busy       = busy_w;
    assign cfg_ena    = drive.ena;
    assign cfg_config = drive.cfg;

endmodule

// File: rtl/reconf_trigger_ctrl_chk.sv
module reconf_trigger_ctrl_chk
    import reconf_pkg::*;
#(
    parameter int unsigned      CLK_PERIOD_PS  = 20000,
    parameter int unsigned      ARM_CYCLES     = 2,
    parameter int unsigned      PULSE_CYCLES   = 4,
    parameter int unsigned      PIN_W          = 3,
    parameter logic [PIN_W-1:0] PIN_IDLE_LEVEL = 3'b101
) (
    input logic             clk,
    input logic             rst,
    input logic             abort,
    input logic [PIN_W-1:0] pin_out,
    input logic             busy,
    input logic [1:0]       cfg_sel,
    input logic             cfg_ena,
    input logic             cfg_config,
    input logic             err_live,
    input logic             err_flag
);

    localparam int unsigned SETTLE_CYC = ceil_div(SETTLE_MIN_PS, CLK_PERIOD_PS) + SETTLE_MARGIN;
    localparam int unsigned CW         = 16;

    logic [CW-1:0] pre_cnt;
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            pre_cnt <= !busy ? '0 : (cfg_config ? pre_cnt : pre_cnt + CW'(1));
            hi_cnt  <= cfg_config ? hi_cnt + CW'(1) : '0;
        end
    end

    a_r4_settle_before_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_config) |-> (pre_cnt == CW'(SETTLE_CYC + ARM_CYCLES)));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_config) |-> (hi_cnt == CW'(PULSE_CYCLES)));

    a_r5_ena_leads_config: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_config) |-> $past(cfg_ena));

    a_r5_ena_covers_config: assert property (@(posedge clk) disable iff (rst)
        cfg_config |-> (cfg_ena && busy));

    a_r3_pins_forced: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pin_out == PIN_IDLE_LEVEL));

    a_r6_sel_stable: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_sel));

    a_r7_abort_cancels: assert property (@(posedge clk) disable iff (rst)
        (abort && busy && !cfg_config) |=> (!busy && !cfg_ena));

    a_r8_live_sets_flag: assert property (@(posedge clk) disable iff (rst)
        err_live |=> err_flag);

endmodule

bind reconf_trigger_ctrl reconf_trigger_ctrl_chk #(
    .CLK_PERIOD_PS  (CLK_PERIOD_PS),
    .ARM_CYCLES     (ARM_CYCLES),
    .PULSE_CYCLES   (PULSE_CYCLES),
    .PIN_W          (PIN_W),
    .PIN_IDLE_LEVEL (PIN_IDLE_LEVEL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .abort      (abort),
    .pin_out    (pin_out),
    .busy       (busy),
    .cfg_sel    (cfg_sel),
    .cfg_ena    (cfg_ena),
    .cfg_config (cfg_config),
    .err_live   (err_live),
    .err_flag   (err_flag)
);

// File: tb/reconf_trigger_ctrl_bench.sv
`timescale 1ns/1ps
module reconf_trigger_ctrl_bench;

    localparam int CLK_PERIOD = 20;
    localparam int PERIOD_PS  = CLK_PERIOD * 1000;
    localparam int ARM        = 2;
    localparam int PULSE      = 4;
    localparam int PIN_W      = 3;
    localparam logic [PIN_W-1:0] IDLE_LVL = 3'b101;
    localparam int SETTLE     = (800000 + PERIOD_PS - 1) / PERIOD_PS + 2;
    localparam int TOTAL      = SETTLE + ARM + PULSE;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [1:0]       req_image = '0;
    logic             abort = 1'b0;
    logic             err_clear = 1'b0;
    logic [PIN_W-1:0] pin_user = '0;
    logic [PIN_W-1:0] pin_out;
    logic             busy;
    logic [1:0]       cfg_sel;
    logic             cfg_ena;
    logic             cfg_config;
    logic             cfg_error_in = 1'b0;
    logic             err_live;
    logic             err_flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reconf_trigger_ctrl #(
        .CLK_PERIOD_PS  (PERIOD_PS),
        .ARM_CYCLES     (ARM),
        .PULSE_CYCLES   (PULSE),
        .PIN_W          (PIN_W),
        .PIN_IDLE_LEVEL (IDLE_LVL)
    ) u_reconf_trigger_ctrl (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_image (req_image),
        .abort (abort), .err_clear (err_clear), .pin_user (pin_user), .pin_out (pin_out),
        .busy (busy), .cfg_sel (cfg_sel), .cfg_ena (cfg_ena), .cfg_config (cfg_config),
        .cfg_error_in (cfg_error_in), .err_live (err_live), .err_flag (err_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected busy end cycle given abort cycle (0 = none)
    function automatic int end_cycle(input int a);
        return (a != 0 && a <= SETTLE + ARM) ? a : TOTAL;
    endfunction

    task automatic run_seq(input logic [1:0] img, input int abort_at, input bit expect_accept,
                           input bit spam);
        logic [1:0] sel_before;
        int         last;
        sel_before = cfg_sel;
        req_valid  = 1'b1;
        req_image  = img;
        pin_user   = PIN_W'($urandom);
        @(negedge clk);
        req_valid = 1'b0;
        if (!expect_accept) begin
            chk(busy == 1'b0, "R10 refused request left busy", busy, 0);
            chk(cfg_sel == sel_before, "R10 refused request changed cfg_sel", cfg_sel, sel_before);
            chk(pin_out == pin_user, "R3 pins follow user when refused", pin_out, pin_user);
            return;
        end
        last = end_cycle(abort_at);
        for (int k = 1; k <= TOTAL + 1; k++) begin
            bit eb, ee, ec;
            eb = (k <= last);
            ee = eb && (k > SETTLE);
            ec = eb && (k > SETTLE + ARM);
            chk(busy == eb, $sformatf("R2/R7 busy k=%0d", k), busy, eb);
            chk(cfg_ena == ee, $sformatf("R4 cfg_ena k=%0d", k), cfg_ena, ee);
            chk(cfg_config == ec, $sformatf("R5 cfg_config k=%0d", k), cfg_config, ec);
            chk(pin_out == (eb ? IDLE_LVL : pin_user), $sformatf("R3 pin_out k=%0d", k),
                pin_out, eb ? IDLE_LVL : pin_user);
            chk(cfg_sel == img, $sformatf("R6 cfg_sel k=%0d", k), cfg_sel, img);
            abort    = (k == abort_at);
            pin_user = PIN_W'($urandom);
            if (spam && eb && k < TOTAL && (abort_at == 0 || k < abort_at)) begin
                req_valid = 1'($urandom);
                req_image = 2'($urandom);
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        abort     = 1'b0;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        repeat (3) @(negedge clk);
        pin_user = 3'b010;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(cfg_ena == 0, "R1 cfg_ena", cfg_ena, 0);
        chk(cfg_config == 0, "R1 cfg_config", cfg_config, 0);
        chk(cfg_sel == 0, "R1 cfg_sel", cfg_sel, 0);
        chk(err_flag == 0 && err_live == 0, "R1 error outputs", {err_live, err_flag}, 0);
        chk(pin_out == pin_user, "R1 pins follow user", pin_out, pin_user);

        // directed: plain sequence, then spam while busy
        run_seq(2'd3, 0, 1'b1, 1'b0);
        run_seq(2'd1, 0, 1'b1, 1'b1);
        // R7: abort in first settle cycle, last arm cycle, during pulse
        run_seq(2'd2, 1, 1'b1, 1'b0);
        run_seq(2'd2, SETTLE + ARM, 1'b1, 1'b0);
        run_seq(2'd1, SETTLE + ARM + 2, 1'b1, 1'b0);

        // R7: abort together with request in idle
        req_valid = 1'b1; req_image = 2'd3; abort = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; abort = 1'b0;
        chk(busy == 0, "R7 abort blocks idle request", busy, 0);
        chk(cfg_sel == 2'd1, "R7 cfg_sel kept on blocked request", cfg_sel, 1);

        // random mix
        for (int t = 0; t < 20; t++) begin
            int a;
            a = ($urandom % 3 == 0) ? 0 : int'($urandom_range(1, TOTAL));
            run_seq(2'($urandom), a, 1'b1, 1'($urandom));
        end

        // R8/R9: error rise collides with a held clear
        err_clear = 1'b1;
        cfg_error_in = 1'b1;
        @(negedge clk);
        chk(err_live == 0, "R8 live after one edge", err_live, 0);
        @(negedge clk);
        chk(err_live == 1, "R8 live after two edges", err_live, 1);
        chk(err_flag == 0, "R8 flag not yet set", err_flag, 0);
        @(negedge clk);
        chk(err_flag == 1, "R9 set wins over clear", err_flag, 1);
        @(negedge clk);
        chk(err_flag == 1, "R9 clear ignored while live", err_flag, 1);
        err_clear = 1'b0;
        cfg_error_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(err_live == 0, "R8 live follows input low", err_live, 0);
        chk(err_flag == 1, "R9 flag sticky", err_flag, 1);

        // R10 gating while the flag is set
        run_seq(2'd2, 0, 1'b0, 1'b0);
        run_seq(2'd0, 0, 1'b1, 1'b0);

        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        chk(err_flag == 0, "R9 clear takes effect", err_flag, 0);
        run_seq(2'd2, 0, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule